// File: doc/BRIEF.md
# Serial Flash Controller Status and Interrupt Unit

This unit gathers event indications from the core of a serial flash controller and presents them to software through a small register window. Three of the indications are levels: receive data ready, transmit data empty and transmitter idle. They are shown as they are. Four are single-cycle pulses: overrun, chip-select rise, chip-select fall and instruction end. Each pulse is caught in a sticky flag. A status read discards those flags, so software can flush stale events before it launches a command. The controller-enabled level also appears in the status word and is never cleared by a read.

Software controls interrupts through a mask. The mask is never written directly. A write to one address sets the mask bits that are one in the data, and a write to another address clears them. A third address reads the mask back. One level interrupt output is high while any status bit that is also unmasked is set. A separate output reports command completion. A command counts as complete only when both the instruction-end flag and the chip-select-rise flag are held.

Top module: `flash_irq_unit`

## Requirements
- R1: After reset the mask register reads 0 and all four sticky flags (bits 3, 8, 9, 10) read 0.
- R2: The status word, read at offset 0x10, has these bits: 0 = receive ready, 1 = transmit empty, 2 = transmitter idle, 3 = overrun, 8 = chip-select rise, 9 = chip-select fall, 10 = instruction end, 24 = controller enabled. All other bits read 0. Bits 0, 1, 2 and 24 follow their inputs in the same cycle.
- R3: An event pulse sets its sticky flag from the next cycle. The flag then holds until a status read.
- R4: A status read returns the flag values from before the read. The sticky flags are cleared in the following cycle.
- R5: If an event pulse arrives in the same cycle as a status read, its flag is set afterwards.
- R6: A status read leaves bits 0, 1, 2 and 24 unchanged.
- R7: A write to offset 0x14 sets each mask bit whose data bit is one. Zero data bits leave the mask unchanged.
- R8: A write to offset 0x18 clears each mask bit whose data bit is one. Zero data bits leave the mask unchanged.
- R9: Offset 0x1C reads the mask. Only the eight status bit positions of R2 can be set. All other mask bits read 0.
- R10: The interrupt output is high exactly when the AND of the status word and the mask is nonzero.
- R11: The command-done output is high exactly when both the instruction-end flag and the chip-select-rise flag are set.
- R12: Reading offsets other than 0x10 does not clear flags. Writing to offsets other than 0x14 and 0x18 does not change the mask. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evRxReady | input | 1 | Receive data ready level |
| evTxEmpty | input | 1 | Transmit data empty level |
| evTxIdle | input | 1 | Transmitter idle level |
| ctrlEnabled | input | 1 | Controller enabled level |
| evOverrun | input | 1 | Overrun event pulse |
| evCsRise | input | 1 | Chip-select rise event pulse |
| evCsFall | input | 1 | Chip-select fall event pulse |
| evInstrEnd | input | 1 | Instruction end event pulse |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write enable |
| busWdata | input | DATA_W | Write data |
| busRe | input | 1 | Read enable; a read of the status word discards the sticky flags |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irq | output | 1 | Level interrupt |
| cmdDone | output | 1 | Instruction end and chip-select rise both flagged |

## Verification
The assertions check the following on every cycle:
- a pulse sets its flag, and the flag holds until a status read;
- a read discards the flags unless a pulse arrives in the same cycle;
- the set and clear writes change only the addressed mask bits;
- the interrupt is silent while the mask is empty;
- command-done implies both of its flags.

Other behaviour is shown only by the bench's scenarios. The bench checks the read-data values against the bit positions and the value returned in the same cycle as a clear. It sweeps every source against every single-bit mask to show the interrupt is exact. It also shows that unmapped and mask-readback accesses leave the flags and the mask alone.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int OFF_STATUS   = 'h10;
  localparam int OFF_MASK_SET = 'h14;
  localparam int OFF_MASK_CLR = 'h18;
  localparam int OFF_MASK     = 'h1C;

  localparam int BIT_RX_READY = 0;
  localparam int BIT_TX_EMPTY = 1;
  localparam int BIT_TX_IDLE  = 2;
  localparam int BIT_ENABLED  = 24;

  localparam int NUM_STICKY = 4;
  localparam int IDX_OVERRUN = 0;
  localparam int IDX_CS_RISE = 1;
  localparam int IDX_CS_FALL = 2;
  localparam int IDX_INSTR   = 3;
  localparam int STICKY_POS [NUM_STICKY] = '{3, 8, 9, 10};

  localparam logic [31:0] IMPL_BITS = 32'h0100_070F;

  typedef struct packed {
    logic selStatus;
    logic selMask;
    logic statusRead;
    logic maskSet;
    logic maskClr;
  } regStrobes_t;
endpackage

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output regStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFF_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFF_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);

  always_comb begin
    strobes            = '0;
    strobes.selStatus  = (busAddr == A_STATUS);
    strobes.selMask    = (busAddr == A_MASK);
    strobes.statusRead = busRe && (busAddr == A_STATUS);
    strobes.maskSet    = busWe && (busAddr == A_SET);
    strobes.maskClr    = busWe && (busAddr == A_CLR);
  end
endmodule

// File: rtl/flash_irq_dp.sv
module flash_irq_dp
  import flash_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  regStrobes_t           strobes,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  rxReady,
  input  logic                  txEmpty,
  input  logic                  txIdle,
  input  logic                  ctrlEnabled,
  input  logic [NUM_STICKY-1:0] evPulse,
  output logic [DATA_W-1:0]     statusWord,
  output logic [DATA_W-1:0]     maskReg,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  irq,
  output logic                  cmdDone
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(IMPL_BITS);

  logic [NUM_STICKY-1:0] stickyQ;
  logic [DATA_W-1:0]     setBits, clrBits;

  // Pulses win over the read-clear so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stickyQ <= '0;
    else        stickyQ <= evPulse | (stickyQ & ~{NUM_STICKY{strobes.statusRead}});
  end

  assign setBits = strobes.maskSet ? busWdata : '0;
  assign clrBits = strobes.maskClr ? busWdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) maskReg <= '0;
    else        maskReg <= (maskReg | setBits) & ~clrBits & IMPL;
  end

  always_comb begin
    statusWord               = '0;
    statusWord[BIT_RX_READY] = rxReady;
    statusWord[BIT_TX_EMPTY] = txEmpty;
    statusWord[BIT_TX_IDLE]  = txIdle;
    statusWord[BIT_ENABLED]  = ctrlEnabled;
    for (int i = 0; i < NUM_STICKY; i++) statusWord[STICKY_POS[i]] = stickyQ[i];
  end

  always_comb begin
    if (strobes.selStatus)    busRdata = statusWord;
    else if (strobes.selMask) busRdata = maskReg;
    else                      busRdata = '0;
  end

  assign irq     = |(statusWord & maskReg);
  assign cmdDone = stickyQ[IDX_INSTR] & stickyQ[IDX_CS_RISE];
endmodule

// File: rtl/flash_irq_unit.sv
module flash_irq_unit
  import flash_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evRxReady,
  input  logic              evTxEmpty,
  input  logic              evTxIdle,
  input  logic              ctrlEnabled,
  input  logic              evOverrun,
  input  logic              evCsRise,
  input  logic              evCsFall,
  input  logic              evInstrEnd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              cmdDone
);
  regStrobes_t           strobes;
  logic [NUM_STICKY-1:0] evPulse;
  logic [DATA_W-1:0]     statusWord;
  logic [DATA_W-1:0]     maskReg;

  always_comb begin
    evPulse              = '0;
    evPulse[IDX_OVERRUN] = evOverrun;
    evPulse[IDX_CS_RISE] = evCsRise;
    evPulse[IDX_CS_FALL] = evCsFall;
    evPulse[IDX_INSTR]   = evInstrEnd;
  end

  flash_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .strobes(strobes)
  );

  flash_irq_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .busWdata(busWdata),
    .rxReady(evRxReady), .txEmpty(evTxEmpty), .txIdle(evTxIdle),
    .ctrlEnabled(ctrlEnabled), .evPulse(evPulse),
    .statusWord(statusWord), .maskReg(maskReg), .busRdata(busRdata),
    .irq(irq), .cmdDone(cmdDone)
  );
endmodule

// File: rtl/flash_irq_chk.sv
module flash_irq_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busWdata,
  input logic              evOverrun,
  input logic              evInstrEnd,
  input logic [DATA_W-1:0] statusWord,
  input logic [DATA_W-1:0] maskReg,
  input logic              irq,
  input logic              cmdDone
);
  logic rdStat, wrSet, wrClr;
  assign rdStat = busRe && (busAddr == ADDR_W'('h10));
  assign wrSet  = busWe && (busAddr == ADDR_W'('h14));
  assign wrClr  = busWe && (busAddr == ADDR_W'('h18));

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evOverrun |=> statusWord[3]); // R3
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[10] && !rdStat) |=> statusWord[10]); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStat && !evOverrun) |=> !statusWord[3]); // R4
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStat && evInstrEnd) |=> statusWord[10]); // R5
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrSet |=> ((maskReg & $past(busWdata & 32'h0100_070F)) == $past(busWdata & 32'h0100_070F))); // R7
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wrClr |=> ((maskReg & $past(busWdata)) == '0)); // R8
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrSet && !wrClr) |=> $stable(maskReg)); // R12
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (maskReg == '0) |-> !irq); // R10
  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdDone |-> (statusWord[10] && statusWord[8])); // R11
endmodule

bind flash_irq_unit flash_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .evOverrun(evOverrun), .evInstrEnd(evInstrEnd),
  .statusWord(statusWord), .maskReg(maskReg), .irq(irq), .cmdDone(cmdDone)
);

// File: tb/tb_flash_irq_unit.sv
module tb_flash_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'h0100_070F;

  logic clk = 0, rst_n = 0;
  logic evRxReady = 0, evTxEmpty = 0, evTxIdle = 0, ctrlEnabled = 0;
  logic evOverrun = 0, evCsRise = 0, evCsFall = 0, evInstrEnd = 0;
  logic [7:0] busAddr = 0;
  logic busWe = 0, busRe = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic irq, cmdDone;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_irq_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRe = 1; #1 d = busRdata;
    @(negedge clk); busRe = 0; busAddr = 0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk); busWe = 0; busWdata = 0; busAddr = 0;
  endtask

  // sticky vector: bit0 overrun, bit1 cs rise, bit2 cs fall, bit3 instr end
  task automatic pulse(input logic [3:0] p);
    @(negedge clk); {evInstrEnd, evCsFall, evCsRise, evOverrun} = p;
    @(negedge clk); {evInstrEnd, evCsFall, evCsRise, evOverrun} = 4'b0;
  endtask

  function automatic logic [31:0] stickyWord(input logic [3:0] p);
    return {21'b0, p[3], p[2], p[1], 4'b0, p[0], 3'b0};
  endfunction

  function automatic int bitPos(input int i);
    case (i)
      0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 8; 5: return 9; 6: return 10; default: return 24;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, expMask;
    repeat (3) @(negedge clk);
    rst_n = 1;

    busRead(8'h1C, d); chk("R1 mask after reset", d, 0);
    busRead(8'h10, d); chk("R1 status after reset", d, 0);

    for (int v = 0; v < 16; v++) begin
      @(negedge clk); {ctrlEnabled, evTxIdle, evTxEmpty, evRxReady} = v[3:0];
      busRead(8'h10, d);
      chk("R2 live levels", d, {7'b0, v[3], 21'b0, v[2:0]});
      busRead(8'h10, d);
      chk("R6 live levels kept after read", d, {7'b0, v[3], 21'b0, v[2:0]});
    end
    @(negedge clk); {ctrlEnabled, evTxIdle, evTxEmpty, evRxReady} = 4'b0;

    for (int p = 1; p < 16; p++) begin
      pulse(p[3:0]);
      #1 chk("R11 cmdDone", {31'b0, cmdDone}, {31'b0, p[3] & p[1]});
      busRead(8'h10, d); chk("R3 sticky set", d, stickyWord(p[3:0]));
      #1 chk("R11 cmdDone after clear", {31'b0, cmdDone}, 0);
      busRead(8'h10, d); chk("R4 cleared after read", d, 0);
    end

    @(negedge clk); busAddr = 8'h10; busRe = 1; evInstrEnd = 1;
    #1 chk("R4 read before event", busRdata, 0);
    @(negedge clk); busRe = 0; evInstrEnd = 0;
    busRead(8'h10, d); chk("R5 event during read kept", d, stickyWord(4'b1000));

    expMask = 0;
    for (int b = 0; b < 8; b++) begin
      busWrite(8'h14, 32'h1 << bitPos(b));
      expMask |= 32'h1 << bitPos(b);
      busRead(8'h1C, d); chk("R7 mask set", d, expMask);
    end
    busWrite(8'h14, 0); busRead(8'h1C, d); chk("R7 zero write no change", d, IMPL);
    for (int b = 0; b < 8; b++) begin
      busWrite(8'h18, 32'h1 << bitPos(b));
      expMask &= ~(32'h1 << bitPos(b));
      busRead(8'h1C, d); chk("R8 mask clear", d, expMask);
    end
    busWrite(8'h14, 32'hFFFF_FFFF); busRead(8'h1C, d); chk("R9 only implemented bits", d, IMPL);
    busWrite(8'h18, 0); busRead(8'h1C, d); chk("R8 zero write no change", d, IMPL);
    busWrite(8'h10, 0); busWrite(8'h1C, 0); busWrite(8'h20, 32'hFFFF_FFFF);
    busRead(8'h1C, d); chk("R12 other writes ignored", d, IMPL);
    busWrite(8'h18, 32'hFFFF_FFFF);

    for (int b = 0; b < 8; b++) begin
      busWrite(8'h14, 32'h1 << bitPos(b));
      for (int s = 0; s < 8; s++) begin
        @(negedge clk);
        case (s)
          0: evRxReady = 1; 1: evTxEmpty = 1; 2: evTxIdle = 1; 7: ctrlEnabled = 1;
          default: ;
        endcase
        if (s >= 3 && s <= 6) pulse(4'b1 << (s - 3));
        #1 chk("R10 irq", {31'b0, irq}, {31'b0, s == b});
        @(negedge clk); {ctrlEnabled, evTxIdle, evTxEmpty, evRxReady} = 4'b0;
        busRead(8'h10, d);
      end
      busWrite(8'h18, 32'h1 << bitPos(b));
    end

    pulse(4'b0001);
    busRead(8'h1C, d); busRead(8'h14, d); chk("R12 unmapped reads 0", d, 0);
    busRead(8'h10, d); chk("R12 other reads do not clear", d, stickyWord(4'b0001));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule